// File: doc/BRIEF.md
# Three-Leg Gate Interlock with Dead Time and Glitch Rejection

This block sits between a pulse-width modulator and the gate drivers of three half-bridge legs. Every leg receives two independent requests, one for its upper switch and one for its lower switch. The block turns these requests into two gate enables per leg. It guarantees that the two switches of a leg are never enabled together. Before any switch is enabled, both gates of that leg stay low for a counted idle interval.

Each leg has its own state machine. All legs run from one clock and one synchronous reset. A qualification filter sits in front of each machine. A request level that does not stay stable for a programmable number of clock edges is dropped, so short pulses and short notches never reach the gates. A request for both switches of a leg at once is treated as illegal. It turns that leg off at once, with no filtering, and raises a one-cycle error flag. The idle interval and the qualification width are shared by all legs. Both are counted in clock cycles.

Top module: `legguard_top`

## Requirements
- R1: While reset is sampled high, every gate enable and every error flag is low on the next cycle and stays low until a command is accepted after reset.
- R2: For any leg, the upper gate and the lower gate are never high in the same cycle.
- R3: Let D = max(deadCycles, 1). A gate goes high only after both gates of its leg have been low for exactly D cycles. The interval starts at the edge where the new request is accepted, and that edge also drops the outgoing gate. deadCycles is sampled only at that edge, so a later change does not affect a running interval.
- R4: A request code is encoded as {upper, lower}: 2'b10 upper, 2'b01 lower, 2'b00 both off. Let W = max(minWidth, 1). A code that differs from the currently accepted one is accepted on the W-th consecutive clock edge that samples it.
- R5: A request level held for fewer than W consecutive edges, whether a pulse or a notch, leaves the gate outputs unchanged.
- R6: The code 2'b11 is illegal. The first edge that samples it drives both gates of that leg low, with no filtering. The leg then counts as having accepted 2'b00, so a later switch request must qualify again and then wait through a full dead interval.
- R7: The error flag of a leg is high for exactly the one cycle that follows the first edge sampling 2'b11. It is not raised again while 2'b11 is held.
- R8: If a different code is accepted while a dead interval is running, the interval restarts in full toward the new target. A request that returns to the original switch therefore waits W edges plus a full D cycles.
- R9: An accepted 2'b00 drives both gates of the leg low at the accepting edge, and no dead interval is started.
- R10: The legs are independent. A request or an illegal code on one leg does not change the gates or the error flag of another leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmdTop | input | NUM_LEGS | Upper-switch request, one bit per leg |
| cmdBot | input | NUM_LEGS | Lower-switch request, one bit per leg |
| deadCycles | input | CNT_W | Dead interval length in clock cycles (0 acts as 1) |
| minWidth | input | CNT_W | Qualification width in clock edges (0 acts as 1) |
| gateTop | output | NUM_LEGS | Upper gate enable, one bit per leg |
| gateBot | output | NUM_LEGS | Lower gate enable, one bit per leg |
| errFlag | output | NUM_LEGS | One-cycle flag for an illegal request, one bit per leg |

## Verification
Take a request that changes just after edge c. It is accepted at edge c+W, so the outgoing gate falls at that edge, and the incoming gate rises at edge c+W+D. An illegal code clears the gates and raises the error flag at edge c+1. A dead-interval restart moves the rising edge to c+2W+D when the reverting request is applied right after acceptance. The bench derives each expected value from these formulas and queues it, tagged with its absolute cycle number. The monitor samples the outputs on the falling clock edge and compares only the entries due in that cycle. It also checks that each expected state is reached no earlier and no later than the cycle the formula gives.

// File: rtl/legguard_pkg.sv
package legguard_pkg;

  // Request code layout: {upper, lower}
  localparam logic [1:0] CODE_OFF = 2'b00;
  localparam logic [1:0] CODE_BOT = 2'b01;
  localparam logic [1:0] CODE_TOP = 2'b10;
  localparam logic [1:0] CODE_BAD = 2'b11;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_TOP      = 3'd1,
    ST_BOT      = 3'd2,
    ST_DEAD_TOP = 3'd3,
    ST_DEAD_BOT = 3'd4
  } legState_t;

  // control -> datapath
  typedef struct packed {
    logic loadDead;
    logic decDead;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       acceptValid;
    logic [1:0] acceptCode;
    logic       improper;
    logic       improperEdge;
    logic       deadDone;
  } dpStatus_t;

endpackage

// File: rtl/legguard_datapath.sv
module legguard_datapath
  import legguard_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdTop,
  input  logic              cmdBot,
  input  logic [CNT_W-1:0]  minWidth,
  input  logic [CNT_W-1:0]  deadCycles,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status
);

  localparam logic [CNT_W:0]   ONE_WIDE = {{CNT_W{1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ONE_NARROW = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W:0]   SAT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [1:0]       inCode;
  logic [1:0]       candCode;
  logic [1:0]       qualCode;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W:0]   freshCnt;
  logic [CNT_W:0]   widthEff;
  logic [CNT_W-1:0] deadCnt;
  logic [CNT_W-1:0] deadLoad;
  logic             prevImproper;
  logic             isImproper;
  logic             acceptNow;

  assign inCode     = {cmdTop, cmdBot};
  assign isImproper = (inCode == CODE_BAD);

  // length of the current run including this edge
  assign freshCnt = (inCode == candCode) ? ({1'b0, runCnt} + ONE_WIDE) : ONE_WIDE;
  assign widthEff = (minWidth == '0) ? ONE_WIDE : {1'b0, minWidth};
  assign acceptNow = !isImproper && (inCode != qualCode) && (freshCnt >= widthEff);

  // qualification filter
  always_ff @(posedge clk) begin
    if (rst) begin
      candCode     <= CODE_OFF;
      runCnt       <= '0;
      qualCode     <= CODE_OFF;
      prevImproper <= 1'b0;
    end else begin
      candCode     <= inCode;
      runCnt       <= (freshCnt > SAT_MAX) ? SAT_MAX[CNT_W-1:0] : freshCnt[CNT_W-1:0];
      prevImproper <= isImproper;
      if (isImproper) begin
        qualCode <= CODE_OFF;
      end else if (acceptNow) begin
        qualCode <= inCode;
      end
    end
  end

  // dead interval counter
  assign deadLoad = (deadCycles == '0) ? ONE_NARROW : deadCycles;

  always_ff @(posedge clk) begin
    if (rst) begin
      deadCnt <= '0;
    end else if (strobe.loadDead) begin
      deadCnt <= deadLoad;
    end else if (strobe.decDead && deadCnt != '0) begin
      deadCnt <= deadCnt - ONE_NARROW;
    end
  end

  always_comb begin
    status.acceptValid  = acceptNow;
    status.acceptCode   = inCode;
    status.improper     = isImproper;
    status.improperEdge = isImproper && !prevImproper;
    status.deadDone     = (deadCnt == ONE_NARROW);
  end

endmodule

// File: rtl/legguard_control.sv
module legguard_control
  import legguard_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        gateTop,
  output logic        gateBot,
  output logic        errFlag
);

  legState_t state;
  legState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (status.improper) begin
      nextState = ST_OFF;
    end else if (status.acceptValid) begin
      unique case (status.acceptCode)
        CODE_TOP: begin
          nextState       = ST_DEAD_TOP;
          strobe.loadDead = 1'b1;
        end
        CODE_BOT: begin
          nextState       = ST_DEAD_BOT;
          strobe.loadDead = 1'b1;
        end
        default: nextState = ST_OFF;
      endcase
    end else begin
      unique case (state)
        ST_DEAD_TOP: begin
          if (status.deadDone) nextState = ST_TOP;
          else strobe.decDead = 1'b1;
        end
        ST_DEAD_BOT: begin
          if (status.deadDone) nextState = ST_BOT;
          else strobe.decDead = 1'b1;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OFF;
      gateTop <= 1'b0;
      gateBot <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state   <= nextState;
      gateTop <= (nextState == ST_TOP);
      gateBot <= (nextState == ST_BOT);
      errFlag <= status.improperEdge;
    end
  end

endmodule

// File: rtl/legguard_leg.sv
module legguard_leg
  import legguard_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdTop,
  input  logic             cmdBot,
  input  logic [CNT_W-1:0] minWidth,
  input  logic [CNT_W-1:0] deadCycles,
  output logic             gateTop,
  output logic             gateBot,
  output logic             errFlag
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  legguard_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .cmdTop     (cmdTop),
    .cmdBot     (cmdBot),
    .minWidth   (minWidth),
    .deadCycles (deadCycles),
    .strobe     (strobe),
    .status     (status)
  );

  legguard_control u_ctl (
    .clk     (clk),
    .rst     (rst),
    .status  (status),
    .strobe  (strobe),
    .gateTop (gateTop),
    .gateBot (gateBot),
    .errFlag (errFlag)
  );

endmodule

// File: rtl/legguard_top.sv
module legguard_top #(
  parameter int NUM_LEGS = 3,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LEGS-1:0] cmdTop,
  input  logic [NUM_LEGS-1:0] cmdBot,
  input  logic [CNT_W-1:0]    deadCycles,
  input  logic [CNT_W-1:0]    minWidth,
  output logic [NUM_LEGS-1:0] gateTop,
  output logic [NUM_LEGS-1:0] gateBot,
  output logic [NUM_LEGS-1:0] errFlag
);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gLeg
    legguard_leg #(.CNT_W(CNT_W)) u_leg (
      .clk        (clk),
      .rst        (rst),
      .cmdTop     (cmdTop[g]),
      .cmdBot     (cmdBot[g]),
      .minWidth   (minWidth),
      .deadCycles (deadCycles),
      .gateTop    (gateTop[g]),
      .gateBot    (gateBot[g]),
      .errFlag    (errFlag[g])
    );
  end

endmodule

// File: rtl/legguard_checker.sv
module legguard_checker #(
  parameter int NUM_LEGS = 3,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_LEGS-1:0] cmdTop,
  input logic [NUM_LEGS-1:0] cmdBot,
  input logic [CNT_W-1:0]    deadCycles,
  input logic [CNT_W-1:0]    minWidth,
  input logic [NUM_LEGS-1:0] gateTop,
  input logic [NUM_LEGS-1:0] gateBot,
  input logic [NUM_LEGS-1:0] errFlag
);

  // R1: reset clears every output on the following cycle
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (gateTop == '0 && gateBot == '0 && errFlag == '0));

  for (genvar i = 0; i < NUM_LEGS; i++) begin : gChk
    // R2
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
      !(gateTop[i] && gateBot[i]));

    // R3: a rising gate was preceded by a cycle with both gates low
    assert_gap_top_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(gateTop[i]) |-> (!$past(gateBot[i]) && !$past(gateTop[i])));

    assert_gap_bot_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(gateBot[i]) |-> (!$past(gateTop[i]) && !$past(gateBot[i])));

    // R6: illegal request clears both gates at the sampling edge
    assert_bad_blocks_R6: assert property (@(posedge clk) disable iff (rst)
      (cmdTop[i] && cmdBot[i]) |=> (!gateTop[i] && !gateBot[i]));

    // R7: error flag lasts one cycle and has an illegal request behind it
    assert_err_single_R7: assert property (@(posedge clk) disable iff (rst)
      errFlag[i] |=> !errFlag[i]);

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(errFlag[i]) |-> $past(cmdTop[i] && cmdBot[i]));
  end

endmodule

bind legguard_top legguard_checker #(.NUM_LEGS(NUM_LEGS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmdTop     (cmdTop),
  .cmdBot     (cmdBot),
  .deadCycles (deadCycles),
  .minWidth   (minWidth),
  .gateTop    (gateTop),
  .gateBot    (gateBot),
  .errFlag    (errFlag)
);

// File: tb/sim_legguard_top.sv
`timescale 1ns/1ps
module sim_legguard_top;

  localparam int LEGS = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [LEGS-1:0] cmdTop = '0;
  logic [LEGS-1:0] cmdBot = '0;
  logic [7:0]      deadCycles = 8'd3;
  logic [7:0]      minWidth = 8'd2;
  logic [LEGS-1:0] gateTop;
  logic [LEGS-1:0] gateBot;
  logic [LEGS-1:0] errFlag;

  legguard_top #(.NUM_LEGS(LEGS), .CNT_W(8)) u0 (
    .clk        (clk),
    .rst        (rst),
    .cmdTop     (cmdTop),
    .cmdBot     (cmdBot),
    .deadCycles (deadCycles),
    .minWidth   (minWidth),
    .gateTop    (gateTop),
    .gateBot    (gateBot),
    .errFlag    (errFlag)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    leg;
    logic  t;
    logic  b;
    logic  e;
    string tag;
  } expItem_t;

  expItem_t pending[$];
  expItem_t keepQ[$];
  int checks = 0;
  int bad = 0;
  bit done = 1'b0;
  int W = 2;
  int D = 3;

  task automatic expectAt(int off, int leg, logic t, logic b, logic e, string tag);
    expItem_t it;
    it.at = cyc + off;
    it.leg = leg;
    it.t = t;
    it.b = b;
    it.e = e;
    it.tag = tag;
    pending.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCmd(int leg, logic t, logic b);
    cmdTop[leg] = t;
    cmdBot[leg] = b;
  endtask

  // monitor: compares queued expectations that fall due in this cycle
  always @(negedge clk) begin
    keepQ.delete();
    if (!rst) begin
      for (int l = 0; l < LEGS; l++) begin
        checks++;
        if (gateTop[l] && gateBot[l]) begin
          bad++;
          $display("FAIL R2 leg%0d cyc%0d: actual top=1 bot=1 expected not both", l, cyc);
        end
      end
    end
    foreach (pending[i]) begin
      if (pending[i].at == cyc) begin
        checks++;
        if (gateTop[pending[i].leg] !== pending[i].t ||
            gateBot[pending[i].leg] !== pending[i].b ||
            errFlag[pending[i].leg] !== pending[i].e) begin
          bad++;
          $display("FAIL %s leg%0d cyc%0d: actual t/b/e=%b%b%b expected %b%b%b",
                   pending[i].tag, pending[i].leg, cyc,
                   gateTop[pending[i].leg], gateBot[pending[i].leg], errFlag[pending[i].leg],
                   pending[i].t, pending[i].b, pending[i].e);
        end
      end else begin
        keepQ.push_back(pending[i]);
      end
    end
    pending = keepQ;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    tick(1);
    for (int l = 0; l < LEGS; l++) expectAt(1, l, 0, 0, 0, "R1");
    tick(2);
    rst = 1'b0;
    for (int l = 0; l < LEGS; l++) expectAt(2, l, 0, 0, 0, "R1");
    tick(3);

    // R4/R3: off -> upper
    setCmd(0, 1, 0);
    expectAt(W - 1, 0, 0, 0, 0, "R4");
    expectAt(W + D - 1, 0, 0, 0, 0, "R3");
    expectAt(W + D, 0, 1, 0, 0, "R4");
    tick(8);

    // R3: upper -> lower hand-over
    setCmd(0, 0, 1);
    expectAt(W - 1, 0, 1, 0, 0, "R4");
    expectAt(W, 0, 0, 0, 0, "R3");
    expectAt(W + D - 1, 0, 0, 0, 0, "R3");
    expectAt(W + D, 0, 0, 1, 0, "R3");
    tick(8);

    // R5: one-cycle notch, then one-cycle opposite pulse
    for (int k = 1; k <= 5; k++) expectAt(k, 0, 0, 1, 0, "R5");
    setCmd(0, 0, 0);
    tick(1);
    setCmd(0, 0, 1);
    tick(5);
    for (int k = 1; k <= 5; k++) expectAt(k, 0, 0, 1, 0, "R5");
    setCmd(0, 1, 0);
    tick(1);
    setCmd(0, 0, 1);
    tick(5);

    // R9: off request
    setCmd(0, 0, 0);
    expectAt(1, 0, 0, 1, 0, "R9");
    expectAt(W, 0, 0, 0, 0, "R9");
    expectAt(W + D + 2, 0, 0, 0, 0, "R9");
    tick(8);
    setCmd(0, 0, 1);
    expectAt(W + D, 0, 0, 1, 0, "R4");
    tick(8);

    // R6/R7: illegal code held three cycles
    setCmd(0, 1, 1);
    expectAt(1, 0, 0, 0, 1, "R6");
    expectAt(2, 0, 0, 0, 0, "R7");
    expectAt(3, 0, 0, 0, 0, "R7");
    tick(3);
    setCmd(0, 0, 1);
    expectAt(W + D - 1, 0, 0, 0, 0, "R6");
    expectAt(W + D, 0, 0, 1, 0, "R6");
    tick(8);

    // R6: single-cycle illegal code bypasses the filter
    setCmd(0, 1, 1);
    expectAt(1, 0, 0, 0, 1, "R6");
    expectAt(2, 0, 0, 0, 0, "R7");
    expectAt(W + D, 0, 0, 0, 0, "R6");
    expectAt(1 + W + D, 0, 0, 1, 0, "R6");
    tick(1);
    setCmd(0, 0, 1);
    tick(9);

    // R8: revert during dead interval restarts it
    setCmd(0, 1, 0);
    expectAt(W, 0, 0, 0, 0, "R8");
    expectAt(W + D, 0, 0, 0, 0, "R8");
    expectAt(2 * W + D - 1, 0, 0, 0, 0, "R8");
    expectAt(2 * W + D, 0, 0, 1, 0, "R8");
    tick(W);
    setCmd(0, 0, 1);
    tick(10);

    // R3/R4: zero settings act as one
    deadCycles = 8'd0;
    minWidth = 8'd0;
    setCmd(0, 1, 0);
    expectAt(1, 0, 0, 0, 0, "R3");
    expectAt(2, 0, 1, 0, 0, "R3");
    tick(4);

    // R3: dead length sampled at interval start
    deadCycles = 8'd5;
    setCmd(0, 0, 1);
    expectAt(1, 0, 0, 0, 0, "R3");
    expectAt(5, 0, 0, 0, 0, "R3");
    expectAt(6, 0, 0, 1, 0, "R3");
    tick(1);
    deadCycles = 8'd2;
    tick(8);

    // R5: wider threshold, leg 1
    minWidth = 8'd4;
    W = 4;
    D = 2;
    for (int k = 1; k <= 10; k++) expectAt(k, 1, 0, 0, 0, "R5");
    setCmd(1, 1, 0);
    tick(3);
    setCmd(1, 0, 0);
    tick(10);
    setCmd(1, 1, 0);
    expectAt(W - 1, 1, 0, 0, 0, "R4");
    expectAt(W + D - 1, 1, 0, 0, 0, "R4");
    expectAt(W + D, 1, 1, 0, 0, "R4");
    tick(8);

    // R10: leg 2 moves while legs 0 and 1 hold
    setCmd(2, 0, 1);
    for (int k = 1; k <= 8; k++) expectAt(k, 1, 1, 0, 0, "R10");
    expectAt(3, 0, 0, 1, 0, "R10");
    expectAt(W + D, 2, 0, 1, 0, "R10");
    tick(8);
    setCmd(1, 1, 1);
    expectAt(1, 1, 0, 0, 1, "R7");
    expectAt(1, 2, 0, 1, 0, "R10");
    expectAt(1, 0, 0, 1, 0, "R10");
    tick(1);
    setCmd(1, 0, 0);
    tick(4);

    // R1: reset in mid-run
    rst = 1'b1;
    for (int l = 0; l < LEGS; l++) expectAt(1, l, 0, 0, 0, "R1");
    tick(2);
    rst = 1'b0;
    for (int l = 0; l < LEGS; l++) setCmd(l, 0, 0);
    tick(3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule